// File: doc/BRIEF.md
# Big-Endian Misaligned Word Fetch

This block turns a byte-addressed 32-bit load into one or two reads of a word-wide synchronous memory. Each memory word holds four bytes. The most significant byte of a word sits at the lowest byte address. The word index is the byte address with its two lowest bits removed. The low two bits give the byte offset inside that word.

When the offset is zero, one memory read supplies the whole result. When the offset is non-zero, the block reads the word that holds the starting byte and then the word after it. It keeps the tail bytes of the first word and the head bytes of the second, in big-endian order. It returns the joined word with a one-cycle valid pulse.

While a load is in flight the block raises busy and ignores new requests. A wrapping counter records how many two-read loads have completed.

Top module: `uwl_load_unit`

## Requirements
- R1: While reset is high and after it is released with no request, `busy_o`, `ld_valid_o` and `mem_re_o` are 0 and `split_count_o` is 0.
- R2: A request is accepted at a rising edge where `ld_req_i` is 1 and the unit is idle. In the next cycle `mem_re_o` is 1 and `mem_waddr_o` equals `ld_addr_i[ADDR_W-1:2]`.
- R3: When `ld_addr_i[1:0]` is 00, the load issues exactly one memory read. `ld_valid_o` is 1 in the second cycle after acceptance. `ld_data_o` then holds the bytes at addresses a, a+1, a+2 and a+3, with byte a in bits [31:24].
- R4: When `ld_addr_i[1:0]` is not 00, the load issues exactly two memory reads in consecutive cycles. The second read's word address is the first plus one. `ld_valid_o` is 1 in the third cycle after acceptance.
- R5: For a non-zero offset k, `ld_data_o` holds the low 4−k bytes of the first word in its most significant positions, followed by the high k bytes of the second word. This equals bytes a..a+3 in big-endian order.
- R6: `ld_valid_o` is high for exactly one cycle per load. `busy_o` is high from the cycle after acceptance through the valid cycle, and low in the following cycle.
- R7: A request made while `busy_o` is 1 is ignored. The load in flight still returns the data for its own address, and no extra memory read follows it.
- R8: `split_count_o` increases by one, modulo 2^CNT_W, for each completed load with a non-zero offset, and is unchanged by aligned loads.
- R9: The second word address wraps from the highest word index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_req_i | input | 1 | Load request, taken when idle |
| ld_addr_i | input | ADDR_W | Byte address of the load |
| busy_o | output | 1 | Load in progress |
| ld_valid_o | output | 1 | Result valid, one cycle |
| ld_data_o | output | 32 | Assembled big-endian word |
| mem_re_o | output | 1 | Memory read strobe |
| mem_waddr_o | output | ADDR_W-2 | Memory word address |
| mem_rdata_i | input | 32 | Memory read data, one cycle after strobe |
| split_count_o | output | CNT_W | Completed two-read loads, wrapping |

## Verification
The bench builds the unit with ADDR_W = 8, which gives a 64-word space. A misaligned load that starts in the last word is then cheap to reach, and it checks that the second read wraps to word 0. CNT_W = 4 lets a run of seventeen misaligned loads carry the split counter past its wrap point. All three non-zero offsets are exercised, together with aligned loads and a request held high during a busy load.

// File: rtl/uwl_pkg.sv
package uwl_pkg;

    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int OFF_W     = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_LAST
    } seq_state_e;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic             split;
    } load_attr_t;

    // Join two big-endian words: drop k leading bytes of hi, fill from lo.
    function automatic logic [WORD_W-1:0] splice_be(
        input logic [WORD_W-1:0] hi,
        input logic [WORD_W-1:0] lo,
        input logic [OFF_W-1:0]  k
    );
        logic [2*WORD_W-1:0] both;
        both = {hi, lo} << {k, 3'b000};
        return both[2*WORD_W-1:WORD_W];
    endfunction

endpackage

// File: rtl/uwl_seq.sv
module uwl_seq
    import uwl_pkg::*;
#(
    parameter int WADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_i,
    input  logic [WADDR_W-1:0] waddr_i,
    input  load_attr_t         attr_i,
    output logic               busy_o,
    output logic               mem_re_o,
    output logic [WADDR_W-1:0] mem_waddr_o,
    output logic               capture_o,
    output logic               finish_o,
    output load_attr_t         attr_o
);

    seq_state_e         state_q, state_d;
    logic [WADDR_W-1:0] waddr_q;
    load_attr_t         attr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) state_d = ST_FIRST;
            ST_FIRST:  state_d = attr_q.split ? ST_SECOND : ST_LAST;
            ST_SECOND: state_d = ST_LAST;
            ST_LAST:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            waddr_q <= '0;
            attr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_i) begin
                waddr_q <= waddr_i;
                attr_q  <= attr_i;
            end
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign mem_re_o    = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign mem_waddr_o = (state_q == ST_SECOND) ? waddr_q + 1'b1 : waddr_q;
    assign capture_o   = (state_q == ST_SECOND);
    assign finish_o    = (state_q == ST_LAST);
    assign attr_o      = attr_q;

    AST_SECOND_READ_NEXT_WORD: assert property (@(posedge clk) disable iff (rst)
        (mem_re_o && $past(mem_re_o)) |-> (mem_waddr_o == $past(mem_waddr_o) + 1'b1)); // R4

    AST_READ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_re_o |-> busy_o); // R3

endmodule

// File: rtl/uwl_merge.sv
module uwl_merge
    import uwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [WORD_W-1:0] rdata_i,
    input  load_attr_t        attr_i,
    output logic [WORD_W-1:0] data_o
);

    logic [WORD_W-1:0] first_q;

    always_ff @(posedge clk) begin
        if (rst)            first_q <= '0;
        else if (capture_i) first_q <= rdata_i;
    end

    always_comb begin
        if (attr_i.split) data_o = splice_be(first_q, rdata_i, attr_i.off);
        else              data_o = rdata_i;
    end

endmodule

// File: rtl/uwl_count.sv
module uwl_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (bump_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    AST_COUNT_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R8

endmodule

// File: rtl/uwl_load_unit.sv
module uwl_load_unit
    import uwl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_req_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    output logic              busy_o,
    output logic              ld_valid_o,
    output logic [WORD_W-1:0] ld_data_o,
    output logic              mem_re_o,
    output logic [ADDR_W-3:0] mem_waddr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [CNT_W-1:0]  split_count_o
);

    localparam int WADDR_W = ADDR_W - OFF_W;

    logic [WADDR_W-1:0] req_waddr;
    load_attr_t         req_attr, cur_attr;
    logic               capture, finish;

    assign req_waddr      = ld_addr_i[ADDR_W-1:OFF_W];
    assign req_attr.off   = ld_addr_i[OFF_W-1:0];
    assign req_attr.split = (ld_addr_i[OFF_W-1:0] != '0);

    uwl_seq #(.WADDR_W(WADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_i       (ld_req_i),
        .waddr_i     (req_waddr),
        .attr_i      (req_attr),
        .busy_o      (busy_o),
        .mem_re_o    (mem_re_o),
        .mem_waddr_o (mem_waddr_o),
        .capture_o   (capture),
        .finish_o    (finish),
        .attr_o      (cur_attr)
    );

    uwl_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .rdata_i   (mem_rdata_i),
        .attr_i    (cur_attr),
        .data_o    (ld_data_o)
    );

    uwl_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .bump_i (finish && cur_attr.split),
        .cnt_o  (split_count_o)
    );

    assign ld_valid_o = finish;

    AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ld_valid_o |=> !ld_valid_o); // R6

    AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        ld_valid_o |-> busy_o); // R6

    AST_IDLE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        ld_valid_o |=> !busy_o); // R6

endmodule

// File: tb/test_uwl_load_unit.sv
module test_uwl_load_unit;

    localparam int ADDR_W = 8;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_req = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              busy, ld_valid, mem_re;
    logic [31:0]       ld_data;
    logic [31:0]       mem_rdata = '0;
    logic [ADDR_W-3:0] mem_waddr;
    logic [CNT_W-1:0]  split_count;

    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;
    logic [3:0] exp_cnt = '0;

    always #2 clk = ~clk;

    uwl_load_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_uwl_load_unit (
        .clk           (clk),
        .rst           (rst),
        .ld_req_i      (ld_req),
        .ld_addr_i     (ld_addr),
        .busy_o        (busy),
        .ld_valid_o    (ld_valid),
        .ld_data_o     (ld_data),
        .mem_re_o      (mem_re),
        .mem_waddr_o   (mem_waddr),
        .mem_rdata_i   (mem_rdata),
        .split_count_o (split_count)
    );

    function automatic logic [7:0] bval(input logic [7:0] a);
        return a * 8'd29 + 8'd17;
    endfunction

    function automatic logic [31:0] word_at(input logic [5:0] w);
        return {bval({w, 2'b00}), bval({w, 2'b01}), bval({w, 2'b10}), bval({w, 2'b11})};
    endfunction

    function automatic logic [31:0] exp_load(input logic [7:0] a);
        return {bval(a), bval(a + 8'd1), bval(a + 8'd2), bval(a + 8'd3)};
    endfunction

    always @(posedge clk) if (mem_re) mem_rdata <= word_at(mem_waddr);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(busy == 0 && ld_valid == 0 && mem_re == 0, "R1 flags in reset",
              {busy, ld_valid, mem_re}, 0);
        check(split_count == 0, "R1 count in reset", split_count, 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(busy == 0 && ld_valid == 0 && mem_re == 0, "R1 flags idle",
              {busy, ld_valid, mem_re}, 0);
    endtask

    // One load; poke keeps a different request active while busy (R7).
    task automatic run_load(input logic [7:0] a, input bit poke);
        bit    split;
        int    last;
        string dtag;
        split = (a[1:0] != 2'b00);
        last  = split ? 3 : 2;
        dtag  = poke ? "R7 data" : (split ? "R5 data" : "R3 data");
        @(negedge clk);
        ld_req  = 1'b1;
        ld_addr = a;
        @(posedge clk);
        for (int n = 1; n <= last; n++) begin
            @(negedge clk);
            if (!poke) ld_req = 1'b0;
            else begin
                ld_addr = ~a;
                if (n == last) ld_req = 1'b0;
            end
            check(busy == 1, "R6 busy", busy, 1);
            check(mem_re == (n < last), split ? "R4 read strobe" : "R3 read strobe",
                  mem_re, (n < last));
            if (n == 1)
                check(mem_waddr == a[7:2], "R2 first word", mem_waddr, a[7:2]);
            if (n == 2 && split)
                check(mem_waddr == a[7:2] + 6'd1, (a[7:2] == 6'h3f) ? "R9 wrap" : "R4 next word",
                      mem_waddr, a[7:2] + 6'd1);
            check(ld_valid == (n == last), "R6 valid timing", ld_valid, (n == last));
            if (n == last)
                check(ld_data == exp_load(a), dtag, ld_data, exp_load(a));
        end
        @(negedge clk);
        check(ld_valid == 0 && busy == 0, "R6 end of load", {ld_valid, busy}, 0);
        check(mem_re == 0, "R7 no extra read", mem_re, 0);
        if (split) exp_cnt = exp_cnt + 4'd1;
        check(split_count == exp_cnt, "R8 count", split_count, exp_cnt);
    endtask

    task automatic test_aligned();
        run_load(8'h00, 1'b0);
        run_load(8'h44, 1'b0);
        run_load(8'hFC, 1'b0);
    endtask

    task automatic test_misaligned();
        run_load(8'h05, 1'b0);
        run_load(8'h06, 1'b0);
        run_load(8'h0B, 1'b0);
        run_load(8'h9E, 1'b0);
    endtask

    task automatic test_wrap();
        run_load(8'hFD, 1'b0);
        run_load(8'hFF, 1'b0);
    endtask

    task automatic test_busy_ignore();
        run_load(8'h21, 1'b1);
        run_load(8'h30, 1'b1);
    endtask

    task automatic test_count_wrap();
        for (int i = 0; i < 17; i++) run_load(8'(i * 4 + 2), 1'b0);
        run_load(8'h10, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        test_aligned();
        test_misaligned();
        test_wrap();
        test_busy_ignore();
        test_count_wrap();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog: actual busy %0d expected completion", busy);
            report();
        end
    end

endmodule